// File: doc/BRIEF.md
# Batched Block Copy Engine with In-Flight Tile Transpose

This block moves 64-byte blocks between a host-visible memory region and a processing-in-memory region without the processor touching each word. Software writes a source address, a destination address and a control word through a small register port; each control-word write queues one copy descriptor. A command write then starts the batch. The engine drains the queue in order. For every burst it makes one read request on the source side, collects eight 64-bit beats in a staging buffer, and then writes those eight beats to the destination. On the way it can turn the 8x8 byte tile on its side.

Each descriptor chooses its own direction, host to PIM or PIM to host. Each request carries a region flag, so the memory side can steer it. When the queue is empty the engine raises an interrupt and holds it until software clears it. Pushing onto a full queue drops the descriptor and sets a sticky error flag.

Top module: `pim_copy_engine`

## Requirements
- R1: Register writes at offset 0 and offset 1 stage a source and a destination byte address. A write at offset 2 queues a descriptor built from the two staged addresses and the written control word: bits [7:0] give the length in 64-byte bursts, bit 8 is the direction and bit 9 enables the transpose. Up to 8 descriptors can be queued.
- R2: A write at offset 2 while 8 descriptors are queued is dropped and sets the overflow flag, which is bit 2 of `reg_status`. Status bits [7:4] show the queue occupancy.
- R3: Descriptors run in the order they were queued. Burst k issues one read request at source+64k, then eight write beats at destination+64k+8j for j = 0..7. Read and write requests are never valid together.
- R4: With transpose enabled, byte i of written beat j equals byte j of read beat i. With it disabled, written beat j equals read beat j.
- R5: Direction 0 means reads go to the host region (`rd_req_pim`=0) and writes go to the PIM region (`wr_req_pim`=1). Direction 1 reverses both flags.
- R6: A descriptor of length 0 completes and issues no read or write request.
- R7: Writing bit 0 at offset 3 starts the batch. The interrupt (`irq`, status bit 1) rises when the queue has drained; if the queue is already empty at start, it rises on the next edge. It stays high until bit 1 is written at offset 3.
- R8: `busy` (status bit 0) is high from the edge after a start with a non-empty queue until the edge on which the last write is accepted. `irq` rises on that same edge. No request is valid while the engine is not busy.
- R9: While a request is valid and its ready is low, valid, address, region flag and data stay unchanged on the next cycle.
- R10: Writing bit 2 at offset 3 clears the overflow flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr_en | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register offset |
| reg_wdata | input | AW | Register write data |
| reg_status | output | PW+5 | {occupancy, 0, overflow, irq, busy} |
| rd_req_valid | output | 1 | Read request valid |
| rd_req_ready | input | 1 | Read request accepted |
| rd_req_addr | output | AW | Read burst byte address |
| rd_req_pim | output | 1 | Read targets the PIM region |
| rd_data_valid | input | 1 | Read return beat valid |
| rd_data | input | DW | Read return beat |
| wr_req_valid | output | 1 | Write beat valid |
| wr_req_ready | input | 1 | Write beat accepted |
| wr_req_addr | output | AW | Write beat byte address |
| wr_req_data | output | DW | Write beat data |
| wr_req_pim | output | 1 | Write targets the PIM region |
| busy | output | 1 | Batch in progress |
| irq | output | 1 | Batch-complete interrupt |

## Verification
The assertions assume the memory side behaves: it returns exactly eight read beats after each accepted read request, and only while the engine waits for them. They also assume software starts a batch only while the engine is idle. The bench memory model queues eight beats per accepted read and inserts random gaps between them. The bench stimulus issues start commands only after the previous interrupt has been seen. Ready signals toggle at random so that stalls land on every beat position.

// File: rtl/pim_copy_engine.sv
module pim_copy_engine #(
  parameter int AW    = 32,
  parameter int DW    = 64,
  parameter int DEPTH = 8,
  parameter int LW    = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          reg_wr_en,
  input  logic [1:0]    reg_addr,
  input  logic [AW-1:0] reg_wdata,
  output logic [$clog2(DEPTH)+4:0] reg_status,
  output logic          rd_req_valid,
  input  logic          rd_req_ready,
  output logic [AW-1:0] rd_req_addr,
  output logic          rd_req_pim,
  input  logic          rd_data_valid,
  input  logic [DW-1:0] rd_data,
  output logic          wr_req_valid,
  input  logic          wr_req_ready,
  output logic [AW-1:0] wr_req_addr,
  output logic [DW-1:0] wr_req_data,
  output logic          wr_req_pim,
  output logic          busy,
  output logic          irq
);
  localparam int NB  = DW / 8;
  localparam int BW  = $clog2(NB);
  localparam int PW  = $clog2(DEPTH);
  localparam int BSH = $clog2(NB * NB);

  typedef enum logic [2:0] {S_IDLE, S_FETCH, S_RREQ, S_RDAT, S_WR} state_t;
  state_t state;

  logic [AW-1:0] src_stage, dst_stage;
  logic [AW-1:0] q_src [DEPTH];
  logic [AW-1:0] q_dst [DEPTH];
  logic [LW-1:0] q_len [DEPTH];
  logic          q_dir [DEPTH];
  logic          q_xp  [DEPTH];
  logic [PW-1:0] head, tail;
  logic [PW:0]   count;
  logic [LW-1:0] burst;
  logic [BW-1:0] beat;
  logic [DW-1:0] stage [NB];
  logic [DW-1:0] tile  [NB];
  logic          ovf;

  wire cmd_wr   = reg_wr_en && reg_addr == 2'd3;
  wire start    = cmd_wr && reg_wdata[0];
  wire full     = count == (PW+1)'(DEPTH);
  wire push_req = reg_wr_en && reg_addr == 2'd2;
  wire push     = push_req && !full;

  wire [LW-1:0] h_len = q_len[head];
  wire          h_xp  = q_xp[head];
  wire last_beat  = beat == BW'(NB-1);
  wire last_burst = burst == h_len - 1'b1;
  wire wr_fire    = wr_req_valid && wr_req_ready;
  wire pop        = (state == S_FETCH && h_len == '0) || (wr_fire && last_beat && last_burst);
  wire drained    = pop && count == (PW+1)'(1) && !push;

  assign busy         = state != S_IDLE;
  assign rd_req_valid = state == S_RREQ;
  assign wr_req_valid = state == S_WR;
  assign rd_req_pim   = q_dir[head];
  assign wr_req_pim   = !q_dir[head];
  assign rd_req_addr  = q_src[head] + (AW'(burst) << BSH);
  assign wr_req_addr  = q_dst[head] + (AW'(burst) << BSH) + (AW'(beat) << BW);
  assign wr_req_data  = h_xp ? tile[beat] : stage[beat];
  assign reg_status   = {count, 1'b0, ovf, irq, busy};

  always_comb
    for (int j = 0; j < NB; j++)
      for (int i = 0; i < NB; i++)
        tile[j][8*i +: 8] = stage[i][8*j +: 8];

  always_ff @(posedge clk) begin
    if (reg_wr_en && reg_addr == 2'd0) src_stage <= reg_wdata;
    if (reg_wr_en && reg_addr == 2'd1) dst_stage <= reg_wdata;
    if (push) begin
      q_src[tail] <= src_stage;
      q_dst[tail] <= dst_stage;
      q_len[tail] <= reg_wdata[LW-1:0];
      q_dir[tail] <= reg_wdata[LW];
      q_xp[tail]  <= reg_wdata[LW+1];
    end
    if (state == S_RDAT && rd_data_valid) stage[beat] <= rd_data;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state <= S_IDLE;
      head  <= '0;
      tail  <= '0;
      count <= '0;
      burst <= '0;
      beat  <= '0;
      irq   <= 1'b0;
      ovf   <= 1'b0;
    end else begin
      if (push) tail <= tail + 1'b1;
      if (pop)  head <= head + 1'b1;
      count <= count + (PW+1)'(push) - (PW+1)'(pop);

      if (push_req && full) ovf <= 1'b1;
      else if (cmd_wr && reg_wdata[2]) ovf <= 1'b0;

      if (drained || (state == S_IDLE && start && count == '0)) irq <= 1'b1;
      else if (cmd_wr && reg_wdata[1]) irq <= 1'b0;

      case (state)
        S_IDLE:  if (start && count != '0) state <= S_FETCH;
        S_FETCH: begin
          burst <= '0;
          beat  <= '0;
          if (h_len == '0) state <= drained ? S_IDLE : S_FETCH;
          else             state <= S_RREQ;
        end
        S_RREQ:  if (rd_req_ready) state <= S_RDAT;
        S_RDAT:  if (rd_data_valid) begin
          beat <= beat + 1'b1;
          if (last_beat) state <= S_WR;
        end
        S_WR:    if (wr_fire) begin
          beat <= beat + 1'b1;
          if (last_beat) begin
            if (!last_burst) begin
              burst <= burst + 1'b1;
              state <= S_RREQ;
            end else state <= drained ? S_IDLE : S_FETCH;
          end
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  assert_no_overflow_R2: assert property (@(posedge clk) disable iff (!rst_n)
    count <= (PW+1)'(DEPTH));
  assert_one_channel_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !(rd_req_valid && wr_req_valid));
  assert_irq_on_drain_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> irq);
  assert_idle_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !rd_req_valid && !wr_req_valid);
  assert_rd_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    rd_req_valid && !rd_req_ready |=> rd_req_valid && $stable(rd_req_addr) && $stable(rd_req_pim));
  assert_wr_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    wr_req_valid && !wr_req_ready |=> wr_req_valid && $stable(wr_req_addr) && $stable(wr_req_data) && $stable(wr_req_pim));
endmodule

// File: tb/pim_copy_engine_tb.sv
module pim_copy_engine_tb;
  logic clk = 0, rst_n = 0;
  logic reg_wr_en = 0;
  logic [1:0] reg_addr = 0;
  logic [31:0] reg_wdata = 0;
  logic [7:0] reg_status;
  logic rd_req_valid, rd_req_ready = 0, rd_req_pim;
  logic [31:0] rd_req_addr, wr_req_addr;
  logic rd_data_valid = 0;
  logic [63:0] rd_data = 0, wr_req_data;
  logic wr_req_valid, wr_req_ready = 0, wr_req_pim, busy, irq;

  pim_copy_engine u_dut (.*);

  always #4 clk = ~clk;

  logic [63:0] host_mem [256], pim_mem [256], exp_host [256], exp_pim [256];
  int checks = 0, fails = 0, nrd = 0, nwr = 0, qcnt = 0, pend = 0;
  logic [31:0] pend_addr;
  logic pend_pim;
  bit done = 0;

  task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial forever begin
    @(negedge clk);
    rd_req_ready = ($urandom % 4) != 0;
    wr_req_ready = ($urandom % 4) != 0;
    rd_data_valid = 0;
    if (pend > 0 && ($urandom % 4) != 0) begin
      automatic logic [7:0] idx = pend_addr[10:3] + 8'(8 - pend);
      rd_data_valid = 1;
      rd_data = pend_pim ? pim_mem[idx] : host_mem[idx];
      pend--;
    end
    if (rd_req_valid && rd_req_ready) begin
      nrd++; pend = 8; pend_addr = rd_req_addr; pend_pim = rd_req_pim;
    end
    if (wr_req_valid && wr_req_ready) begin
      nwr++;
      if (wr_req_pim) pim_mem[wr_req_addr[10:3]] = wr_req_data;
      else host_mem[wr_req_addr[10:3]] = wr_req_data;
    end
  end

  task automatic reg_write(input logic [1:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_wr_en = 1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr_en = 0;
  endtask

  function automatic logic [63:0] tile_word(input logic [63:0] t [8], input int j);
    logic [63:0] w;
    for (int i = 0; i < 8; i++) w[8*i +: 8] = t[i][8*j +: 8];
    return w;
  endfunction

  task automatic model(input int sb, input int db, input int len, input bit dir, input bit xp);
    logic [63:0] t [8];
    for (int b = 0; b < len; b++) begin
      for (int w = 0; w < 8; w++) t[w] = dir ? exp_pim[(sb+b)*8+w] : exp_host[(sb+b)*8+w];
      for (int w = 0; w < 8; w++) begin
        automatic logic [63:0] v = xp ? tile_word(t, w) : t[w];
        if (dir) exp_host[(db+b)*8+w] = v; else exp_pim[(db+b)*8+w] = v;
      end
    end
  endtask

  // R1: push one descriptor (burst indices within a 2 KB window)
  task automatic push(input int sb, input int db, input int len, input bit dir, input bit xp);
    reg_write(2'd0, 32'(sb * 64));
    reg_write(2'd1, 32'(db * 64));
    reg_write(2'd2, {22'd0, xp, dir, 8'(len)});
    if (qcnt < 8) begin
      model(sb, db, len, dir, xp);
      qcnt++;
    end
  endtask

  task automatic run_batch(input int exp_bursts, input string tag);
    int rd0 = nrd, wr0 = nwr, bad = 0, first = -1;
    reg_write(2'd3, 32'd1);
    if (qcnt > 0) check(busy == 1, "R8 busy after start", 64'(busy), 1);
    while (!irq) @(negedge clk);
    check(busy == 0, "R8 busy low when irq rises", 64'(busy), 0);
    for (int k = 0; k < 256; k++)
      if (host_mem[k] !== exp_host[k] || pim_mem[k] !== exp_pim[k]) begin
        bad++; if (first < 0) first = k;
      end
    check(bad == 0, {tag, " R3 R4 R5 memory contents"}, 64'(bad), 0);
    check(nrd - rd0 == exp_bursts && nwr - wr0 == 8 * exp_bursts, {tag, " R3 R6 request count"},
          64'(nrd - rd0), 64'(exp_bursts));
    reg_write(2'd3, 32'd2);
    check(irq == 0, "R7 irq cleared", 64'(irq), 0);
    qcnt = 0;
  endtask

  initial begin
    void'($urandom(32'd1234));
    for (int k = 0; k < 256; k++) begin
      host_mem[k] = {$urandom, $urandom}; pim_mem[k] = {$urandom, $urandom};
      exp_host[k] = host_mem[k]; exp_pim[k] = pim_mem[k];
    end
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    check(reg_status == 8'd0 && !rd_req_valid && !wr_req_valid, "R8 reset state", 64'(reg_status), 0);

    // R7: start with empty queue
    reg_write(2'd3, 32'd1);
    check(irq == 1 && busy == 0, "R7 empty start irq", 64'({irq, busy}), 64'd2);
    reg_write(2'd3, 32'd2);

    // R6: zero-length only
    push(1, 2, 0, 0, 0); push(3, 4, 0, 1, 1);
    run_batch(0, "zero-len");

    // R4: directed transpose of a known tile
    for (int i = 0; i < 8; i++)
      for (int j = 0; j < 8; j++) begin
        host_mem[i][8*j +: 8] = 8'(16 * i + j); exp_host[i][8*j +: 8] = 8'(16 * i + j);
      end
    push(0, 5, 1, 0, 1);
    run_batch(1, "transpose");
    check(pim_mem[5*8+3] == 64'h7363534333231303, "R4 tile word 3", pim_mem[43], 64'h7363534333231303);

    // R3: in-order, later descriptor wins on shared destination
    push(10, 20, 2, 1, 0); push(12, 20, 2, 1, 0);
    run_batch(4, "order");
    check(host_mem[20*8] == pim_mem[12*8], "R3 order last writer", host_mem[160], pim_mem[96]);

    // R2 / R10: overflow
    for (int n = 0; n < 9; n++) push(n, 16 + n, 1, 0, 0);
    @(negedge clk);
    check(reg_status[2] == 1 && reg_status[7:4] == 4'd8, "R2 overflow flag and count",
          64'(reg_status), 64'h84);
    run_batch(8, "overflow");
    reg_write(2'd3, 32'd4);
    check(reg_status[2] == 0, "R10 overflow cleared", 64'(reg_status), 0);

    // R1 R3 R4 R5 R6: random batches
    for (int b = 0; b < 8; b++) begin
      automatic int nd = 1 + $urandom % 4, tot = 0;
      for (int d = 0; d < nd; d++) begin
        automatic int len = $urandom % 4;
        push($urandom % 29, $urandom % 29, len, 1'($urandom), 1'($urandom));
        tot += len;
      end
      run_batch(tot, "random");
    end
    finish_run();
  end
endmodule